// File: doc/BRIEF.md
# Smart Card Character Framer

This block moves asynchronous smart card characters over one half-duplex line. A character is a low start bit, eight data bits and one parity bit. The transmitter then holds the line high for a guard period before the next character. The length of each bit is one elementary time unit (ETU), set in system clocks by a divider input. The host hands bytes to the transmitter through a valid/ready pair and takes received bytes from a valid/ready pair. Each received byte comes with a parity-error flag. A one-cycle pulse marks the end of each transmitted character.

Two configuration bits shape the eight data bits on the way to and from the line. The order bit sends the most significant bit first. The invert bit swaps the line levels used for data ones and zeros. Parity has its own odd/even selection, and the invert bit never touches the parity bit. This lets one datapath serve both the direct and the inverse card convention. The host sets order, invert and odd parity together for inverse-convention cards, and clears all three for direct-convention cards.

A framing-enable bit turns the whole block on. Separate enables gate the transmit path, the receive path, the two interrupt requests and a divided card clock output.

Top module: `sc_framer`

## Requirements
- R1: After synchronous reset, line_o is high, card_clk is low, rx_valid and tx_done are low, and tx_ready is high when cfg_sc_mode and cfg_tx_en are set.
- R2: An accepted byte becomes a frame of exactly etu_div clock cycles per bit: a start bit at low level, eight data bits, then a parity bit. The line then stays high for two ETUs of guard time. tx_done pulses for one cycle when the guard time ends. The next start bit can follow one cycle later at the earliest.
- R3: With cfg_dir=0 data bit 0 goes on the line first. With cfg_dir=1 data bit 7 goes first. The receiver applies the same order.
- R4: With cfg_inv=0 a data one is the high level. With cfg_inv=1 a data one is the low level. The start bit, the parity bit and the guard time are not inverted. The receiver applies the same rule.
- R5: The parity bit's line level makes the number of high levels among the eight data levels plus parity even when cfg_odd=0 and odd when cfg_odd=1. Byte 0x3B sent with cfg_dir=0, cfg_inv=0, cfg_odd=0 has its parity at the high level. Byte 0x3F sent with cfg_dir=1, cfg_inv=1, cfg_odd=1 has its parity at the high level.
- R6: The receiver times each bit from the falling edge of the start bit and samples it at mid-unit. It presents the recovered byte on rx_data with rx_valid high. rx_valid stays high until a cycle with rx_ready high.
- R7: When the received parity level does not satisfy R5 for the configured mode, rx_perr is high alongside the byte, and the byte is still delivered.
- R8: A low pulse on line_i that has ended before mid-unit of the start bit delivers no byte, and the receiver then accepts the next real frame.
- R9: tx_ready is low unless cfg_sc_mode and cfg_tx_en are both high. The receiver ignores line_i unless cfg_sc_mode and cfg_rx_en are both high. With cfg_sc_mode low, line_o stays high.
- R10: With cfg_sc_mode and cfg_clk_en high, card_clk toggles every CARD_HALF clock cycles. Otherwise card_clk is held low.
- R11: irq_tx is high exactly when cfg_tx_ie and tx_ready are high. irq_rx is high exactly when cfg_rx_ie and rx_valid are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sc_mode | input | 1 | Enables smart card framing |
| cfg_dir | input | 1 | 1: most significant data bit first |
| cfg_inv | input | 1 | 1: data ones at low line level |
| cfg_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_tx_en | input | 1 | Transmit path enable |
| cfg_rx_en | input | 1 | Receive path enable |
| cfg_tx_ie | input | 1 | Transmit interrupt enable |
| cfg_rx_ie | input | 1 | Receive interrupt enable |
| cfg_clk_en | input | 1 | Card clock output enable |
| etu_div | input | ETU_W | Clock cycles per ETU (at least 4) |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Transmitter can accept a byte |
| tx_done | output | 1 | One-cycle pulse at end of guard time |
| rx_data | output | 8 | Received byte |
| rx_perr | output | 1 | Parity error on rx_data |
| rx_valid | output | 1 | rx_data holds an unread byte |
| rx_ready | input | 1 | Host takes the received byte |
| line_i | input | 1 | Serial line as seen by the receiver |
| line_o | output | 1 | Serial line level driven by the transmitter |
| card_clk | output | 1 | Divided card clock |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |

## Verification
Frames are sent and received under all four combinations of order and inversion. Non-symmetric bytes such as 0xA5 and 0x96 show a swapped order or a missed inversion as a different level pattern. The two start characters 0x3B and 0x3F appear under their own conventions, and their line patterns are compared with fixed expected values. These patterns show whether the invert bit wrongly reaches the parity bit. A received frame with a flipped parity level separates error flagging from byte loss. A short low glitch, a frame sent with reception disabled, and a back-to-back pair that measures the spacing between start bits check rejection and guard timing.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic sc_mode;
        logic dir;
        logic inv;
        logic odd;
    } sc_frame_cfg_t;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PAR,
        TX_GUARD
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_BITS
    } rx_state_e;

    function automatic logic [BYTE_W-1:0] sc_rev8(input logic [BYTE_W-1:0] d);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = d[BYTE_W-1-i];
        return r;
    endfunction

    // byte -> line levels, element 0 leaves first
    function automatic logic [BYTE_W-1:0] sc_to_line(input logic [BYTE_W-1:0] d,
                                                     input sc_frame_cfg_t c);
        logic [BYTE_W-1:0] ord;
        ord = c.dir ? sc_rev8(d) : d;
        return ord ^ {BYTE_W{c.inv}};
    endfunction

    // line levels (element 0 arrived first) -> byte
    function automatic logic [BYTE_W-1:0] sc_from_line(input logic [BYTE_W-1:0] lv,
                                                       input sc_frame_cfg_t c);
        logic [BYTE_W-1:0] ord;
        ord = lv ^ {BYTE_W{c.inv}};
        return c.dir ? sc_rev8(ord) : ord;
    endfunction

    // parity level computed over the data levels as they sit on the line
    function automatic logic sc_par_level(input logic [BYTE_W-1:0] lv, input logic odd);
        return (^lv) ^ odd;
    endfunction

endpackage

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
    parameter int ETU_W    = 12,
    parameter bit MID_TICK = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [ETU_W-1:0] etu_div,
    output logic             tick
);
    logic [ETU_W-1:0] cnt;
    logic [ETU_W-1:0] target;
    logic [ETU_W-1:0] last;

    assign last = etu_div - ETU_W'(1);

    generate
        if (MID_TICK) begin : g_mid
            assign target = etu_div >> 1;
        end else begin : g_end
            assign target = last;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            cnt <= '0;
        end else if (cnt == last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + ETU_W'(1);
        end
    end

    assign tick = run && !restart && (cnt == target);
endmodule

// File: rtl/sc_tx.sv
module sc_tx
    import sc_pkg::*;
#(
    parameter int ETU_W     = 12,
    parameter int GUARD_ETU = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  sc_frame_cfg_t       cfg,
    input  logic                tx_en,
    input  logic [ETU_W-1:0]    etu_div,
    input  logic [BYTE_W-1:0]   tx_data,
    input  logic                tx_valid,
    output logic                tx_ready,
    output logic                tx_done,
    output logic                line_o
);
    localparam int GW = (GUARD_ETU > 1) ? $clog2(GUARD_ETU) : 1;
    localparam int IW = $clog2(BYTE_W);

    tx_state_e         st;
    logic [BYTE_W-1:0] shreg;
    logic              par;
    logic [IW-1:0]     idx;
    logic [GW-1:0]     gcnt;
    logic              accept;
    logic              tick;

    assign tx_ready = (st == TX_IDLE) && cfg.sc_mode && tx_en;
    assign accept   = tx_ready && tx_valid;

    sc_etu_timer #(.ETU_W(ETU_W), .MID_TICK(1'b0)) u_bit_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     (st != TX_IDLE),
        .restart (accept),
        .etu_div (etu_div),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (rst || !cfg.sc_mode) begin
            st      <= TX_IDLE;
            line_o  <= 1'b1;
            shreg   <= '0;
            par     <= 1'b0;
            idx     <= '0;
            gcnt    <= '0;
            tx_done <= 1'b0;
        end else begin
            tx_done <= 1'b0;
            unique case (st)
                TX_IDLE: begin
                    if (accept) begin
                        shreg  <= sc_to_line(tx_data, cfg);
                        par    <= sc_par_level(sc_to_line(tx_data, cfg), cfg.odd);
                        line_o <= 1'b0;
                        st     <= TX_START;
                    end
                end
                TX_START: begin
                    if (tick) begin
                        line_o <= shreg[0];
                        shreg  <= shreg >> 1;
                        idx    <= '0;
                        st     <= TX_DATA;
                    end
                end
                TX_DATA: begin
                    if (tick) begin
                        if (idx == IW'(BYTE_W - 1)) begin
                            line_o <= par;
                            st     <= TX_PAR;
                        end else begin
                            line_o <= shreg[0];
                            shreg  <= shreg >> 1;
                            idx    <= idx + IW'(1);
                        end
                    end
                end
                TX_PAR: begin
                    if (tick) begin
                        line_o <= 1'b1;
                        gcnt   <= '0;
                        st     <= TX_GUARD;
                    end
                end
                TX_GUARD: begin
                    if (tick) begin
                        if (gcnt == GW'(GUARD_ETU - 1)) begin
                            tx_done <= 1'b1;
                            st      <= TX_IDLE;
                        end else begin
                            gcnt <= gcnt + GW'(1);
                        end
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sc_rx.sv
module sc_rx
    import sc_pkg::*;
#(
    parameter int ETU_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  sc_frame_cfg_t       cfg,
    input  logic                rx_en,
    input  logic [ETU_W-1:0]    etu_div,
    input  logic                line_i,
    input  logic                rx_ready,
    output logic [BYTE_W-1:0]   rx_data,
    output logic                rx_perr,
    output logic                rx_valid
);
    localparam int IW = $clog2(BYTE_W + 1);

    rx_state_e         st;
    logic              s1, s2, s_prev;
    logic              fall;
    logic              active;
    logic              restart;
    logic              tick;
    logic [BYTE_W-1:0] lv;
    logic [IW-1:0]     idx;
    logic              deliver;

    assign active  = cfg.sc_mode && rx_en;
    assign fall    = s_prev && !s2;
    assign restart = (st == RX_IDLE) && active && fall;
    assign deliver = (st == RX_BITS) && tick && (idx == IW'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= 1'b1;
            s2     <= 1'b1;
            s_prev <= 1'b1;
        end else begin
            s1     <= line_i;
            s2     <= s1;
            s_prev <= s2;
        end
    end

    sc_etu_timer #(.ETU_W(ETU_W), .MID_TICK(1'b1)) u_smp_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     (st != RX_IDLE),
        .restart (restart),
        .etu_div (etu_div),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            st  <= RX_IDLE;
            lv  <= '0;
            idx <= '0;
        end else begin
            unique case (st)
                RX_IDLE: begin
                    if (restart) st <= RX_START;
                end
                RX_START: begin
                    if (tick) begin
                        idx <= '0;
                        st  <= s2 ? RX_IDLE : RX_BITS;
                    end
                end
                RX_BITS: begin
                    if (tick) begin
                        if (idx == IW'(BYTE_W)) begin
                            st <= RX_IDLE;
                        end else begin
                            lv  <= {s2, lv[BYTE_W-1:1]};
                            idx <= idx + IW'(1);
                        end
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data  <= '0;
            rx_perr  <= 1'b0;
            rx_valid <= 1'b0;
        end else if (deliver) begin
            rx_data  <= sc_from_line(lv, cfg);
            rx_perr  <= (s2 != sc_par_level(lv, cfg.odd));
            rx_valid <= 1'b1;
        end else if (rx_ready) begin
            rx_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/sc_cardclk.sv
module sc_cardclk #(
    parameter int CARD_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic card_clk
);
    localparam int CW = (CARD_HALF > 1) ? $clog2(CARD_HALF) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt      <= '0;
            card_clk <= 1'b0;
        end else if (cnt == CW'(CARD_HALF - 1)) begin
            cnt      <= '0;
            card_clk <= !card_clk;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/sc_framer.sv
module sc_framer
    import sc_pkg::*;
#(
    parameter int ETU_W     = 12,
    parameter int GUARD_ETU = 2,
    parameter int CARD_HALF = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_sc_mode,
    input  logic              cfg_dir,
    input  logic              cfg_inv,
    input  logic              cfg_odd,
    input  logic              cfg_tx_en,
    input  logic              cfg_rx_en,
    input  logic              cfg_tx_ie,
    input  logic              cfg_rx_ie,
    input  logic              cfg_clk_en,
    input  logic [ETU_W-1:0]  etu_div,
    input  logic [7:0]        tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_done,
    output logic [7:0]        rx_data,
    output logic              rx_perr,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic              line_i,
    output logic              line_o,
    output logic              card_clk,
    output logic              irq_tx,
    output logic              irq_rx
);
    sc_frame_cfg_t fcfg;

    assign fcfg = '{sc_mode: cfg_sc_mode, dir: cfg_dir, inv: cfg_inv, odd: cfg_odd};

    sc_tx #(.ETU_W(ETU_W), .GUARD_ETU(GUARD_ETU)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .cfg      (fcfg),
        .tx_en    (cfg_tx_en),
        .etu_div  (etu_div),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tx_done  (tx_done),
        .line_o   (line_o)
    );

    sc_rx #(.ETU_W(ETU_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .cfg      (fcfg),
        .rx_en    (cfg_rx_en),
        .etu_div  (etu_div),
        .line_i   (line_i),
        .rx_ready (rx_ready),
        .rx_data  (rx_data),
        .rx_perr  (rx_perr),
        .rx_valid (rx_valid)
    );

    sc_cardclk #(.CARD_HALF(CARD_HALF)) u_cclk (
        .clk      (clk),
        .rst      (rst),
        .enable   (cfg_sc_mode && cfg_clk_en),
        .card_clk (card_clk)
    );

    assign irq_tx = cfg_tx_ie && tx_ready;
    assign irq_rx = cfg_rx_ie && rx_valid;
endmodule

// File: rtl/sc_framer_chk.sv
module sc_framer_chk (
    input logic clk,
    input logic rst,
    input logic cfg_sc_mode,
    input logic cfg_clk_en,
    input logic tx_valid,
    input logic tx_ready,
    input logic tx_done,
    input logic rx_valid,
    input logic rx_ready,
    input logic line_o,
    input logic card_clk
);
    // R2: end-of-character pulse lasts a single cycle
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done);

    // R2: an accepted byte occupies the transmitter
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R6: an unread byte stays presented until the host takes it
    a_r6_valid_hold: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> rx_valid);

    // R9: framing disabled keeps the line idle high
    a_r9_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        !cfg_sc_mode |=> line_o);

    // R10: card clock held low when not enabled
    a_r10_clk_gated: assert property (@(posedge clk) disable iff (rst)
        !(cfg_sc_mode && cfg_clk_en) |=> !card_clk);
endmodule

bind sc_framer sc_framer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_sc_mode (cfg_sc_mode),
    .cfg_clk_en  (cfg_clk_en),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_done     (tx_done),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .line_o      (line_o),
    .card_clk    (card_clk)
);

// File: tb/sc_framer_tb_top.sv
module sc_framer_tb_top;
    localparam int ETU   = 16;
    localparam int ETU_W = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_sc_mode = 1'b1, cfg_dir = 1'b0, cfg_inv = 1'b0, cfg_odd = 1'b0;
    logic             cfg_tx_en = 1'b1, cfg_rx_en = 1'b1, cfg_tx_ie = 1'b0, cfg_rx_ie = 1'b0;
    logic             cfg_clk_en = 1'b0;
    logic [ETU_W-1:0] etu_div = ETU_W'(ETU);
    logic [7:0]       tx_data = 8'h00;
    logic             tx_valid = 1'b0;
    logic             tx_ready, tx_done;
    logic [7:0]       rx_data;
    logic             rx_perr, rx_valid;
    logic             rx_ready = 1'b1;
    logic             line_i = 1'b1;
    logic             line_o, card_clk, irq_tx, irq_rx;

    always #10ns clk = !clk;

    sc_framer #(.ETU_W(ETU_W)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_sc_mode(cfg_sc_mode), .cfg_dir(cfg_dir), .cfg_inv(cfg_inv), .cfg_odd(cfg_odd),
        .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en), .cfg_tx_ie(cfg_tx_ie),
        .cfg_rx_ie(cfg_rx_ie), .cfg_clk_en(cfg_clk_en), .etu_div(etu_div),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_done(tx_done),
        .rx_data(rx_data), .rx_perr(rx_perr), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .line_i(line_i), .line_o(line_o), .card_clk(card_clk),
        .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0, n_done = 0, n_rx = 0;
    bit finished = 0;
    string tx_tag = "R2", rx_tag = "R6";
    logic [9:0] txq[$];
    logic [8:0] rxq[$];
    int falls[$];

    always @(posedge clk) cyc++;
    always @(negedge clk) if (tx_done) n_done++;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // frame as bit vector: [0] start, [8:1] data levels in line order, [9] parity level
    function automatic logic [9:0] exp_frame(input logic [7:0] d, input bit dir,
                                             input bit inv, input bit odd);
        logic [7:0] lv;
        int ones = 0;
        for (int i = 0; i < 8; i++) begin
            lv[i] = (dir ? d[7-i] : d[i]) ^ inv;
            if (lv[i]) ones++;
        end
        return {logic'(ones % 2 == 1) ^ logic'(odd), lv, 1'b0};
    endfunction

    task automatic set_cfg(input bit dir, input bit inv, input bit odd);
        @(negedge clk);
        cfg_dir = dir; cfg_inv = inv; cfg_odd = odd;
    endtask

    task automatic send_byte(input logic [7:0] d);
        txq.push_back(exp_frame(d, cfg_dir, cfg_inv, cfg_odd));
        tx_data  = d;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic card_send(input logic [7:0] d, input bit bad_par, input bit expect_it);
        logic [9:0] f;
        f = exp_frame(d, cfg_dir, cfg_inv, cfg_odd);
        f[9] = f[9] ^ bad_par;
        if (expect_it) rxq.push_back({bad_par, d});
        for (int b = 0; b < 10; b++) begin
            line_i = f[b];
            repeat (ETU) @(negedge clk);
        end
        line_i = 1'b1;
        repeat (2 * ETU) @(negedge clk);
    endtask

    // transmit monitor: decode line_o like a card would
    initial begin
        forever begin
            logic [9:0] got;
            logic [9:0] exp;
            @(negedge line_o);
            falls.push_back(cyc);
            repeat (ETU / 2) @(negedge clk);
            got[0] = line_o;
            for (int b = 1; b < 10; b++) begin
                repeat (ETU) @(negedge clk);
                got[b] = line_o;
            end
            if (txq.size() == 0) begin
                chk(1'b0, tx_tag, "unexpected tx frame", 32'(got), 32'h0);
            end else begin
                exp = txq.pop_front();
                chk(got == exp, tx_tag, "tx frame levels", 32'(got), 32'(exp));
            end
        end
    end

    // receive monitor: one comparison per delivered byte
    initial begin
        bit seen = 0;
        forever begin
            @(negedge clk);
            if (rx_valid && !seen) begin
                logic [8:0] e;
                seen = 1;
                n_rx++;
                if (rxq.size() == 0) begin
                    chk(1'b0, rx_tag, "unexpected rx byte", {23'd0, rx_perr, rx_data}, 32'h0);
                end else begin
                    e = rxq.pop_front();
                    chk({rx_perr, rx_data} == e, rx_tag, "rx byte/perr",
                        {23'd0, rx_perr, rx_data}, {23'd0, e});
                end
            end
            if (!rx_valid) seen = 0;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int d0, r0, toggles;
        logic prev;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(line_o == 1'b1, "R1", "line_o", line_o, 1);
        chk(card_clk == 1'b0, "R1", "card_clk", card_clk, 0);
        chk(rx_valid == 1'b0 && tx_done == 1'b0, "R1", "rx_valid/tx_done", {rx_valid, tx_done}, 0);
        chk(tx_ready == 1'b1, "R1", "tx_ready", tx_ready, 1);

        // R5 fixed start-character patterns
        chk(exp_frame(8'h3B, 0, 0, 0) == 10'h276, "R5", "direct start char model",
            32'(exp_frame(8'h3B, 0, 0, 0)), 32'h276);
        chk(exp_frame(8'h3F, 1, 1, 1) == 10'h206, "R5", "inverse start char model",
            32'(exp_frame(8'h3F, 1, 1, 1)), 32'h206);

        // R3 R4 R5 transmit under each convention
        tx_tag = "R5 direct";
        set_cfg(0, 0, 0); send_byte(8'h3B); repeat (13 * ETU) @(negedge clk);
        tx_tag = "R5 inverse";
        set_cfg(1, 1, 1); send_byte(8'h3F); repeat (13 * ETU) @(negedge clk);
        tx_tag = "R3 msb first";
        set_cfg(1, 0, 0); send_byte(8'hA5); repeat (13 * ETU) @(negedge clk);
        tx_tag = "R4 inverted";
        set_cfg(0, 1, 0); send_byte(8'h96); repeat (13 * ETU) @(negedge clk);
        chk(txq.size() == 0, "R2", "tx frames seen", txq.size(), 0);
        chk(n_done == 4, "R2", "tx_done pulses", n_done, 4);

        // R2 guard time: spacing between start bits of back-to-back frames
        tx_tag = "R2 burst";
        set_cfg(0, 0, 1);
        falls.delete();
        send_byte(8'h55);
        send_byte(8'hC3);
        repeat (13 * ETU) @(negedge clk);
        chk(falls.size() == 2, "R2", "burst frame count", falls.size(), 2);
        if (falls.size() == 2) begin
            d0 = falls[1] - falls[0];
            chk(d0 >= 12 * ETU && d0 <= 12 * ETU + 2, "R2", "start spacing cycles", d0, 12 * ETU + 1);
        end

        // R11 transmit interrupt
        @(negedge clk); cfg_tx_ie = 1'b1; @(negedge clk);
        chk(irq_tx == 1'b1, "R11", "irq_tx idle", irq_tx, 1);
        cfg_tx_en = 1'b0; @(negedge clk);
        // R9 transmit gated
        chk(tx_ready == 1'b0 && irq_tx == 1'b0, "R9", "tx_ready/irq_tx with tx off",
            {tx_ready, irq_tx}, 0);
        cfg_tx_en = 1'b1; cfg_tx_ie = 1'b0;

        // R6 R3 R4 receive under each convention
        rx_tag = "R6 direct";
        set_cfg(0, 0, 0); card_send(8'h3B, 0, 1);
        rx_tag = "R6 inverse";
        set_cfg(1, 1, 1); card_send(8'h3F, 0, 1);
        rx_tag = "R3 rx msb first";
        set_cfg(1, 0, 0); card_send(8'hA5, 0, 1);
        rx_tag = "R4 rx inverted";
        set_cfg(0, 1, 1); card_send(8'h96, 0, 1);
        // R7 parity error still delivers the byte
        rx_tag = "R7 perr";
        set_cfg(0, 0, 0); card_send(8'h5A, 1, 1);
        repeat (4) @(negedge clk);
        chk(rxq.size() == 0 && n_rx == 5, "R6", "bytes received", n_rx, 5);

        // R8 glitch rejected, then a real frame received
        r0 = n_rx;
        line_i = 1'b0; repeat (ETU / 4) @(negedge clk);
        line_i = 1'b1; repeat (3 * ETU) @(negedge clk);
        chk(n_rx == r0, "R8", "bytes after glitch", n_rx - r0, 0);
        rx_tag = "R8 recovery";
        card_send(8'h81, 0, 1);
        repeat (4) @(negedge clk);
        chk(n_rx == r0 + 1, "R8", "byte after recovery", n_rx - r0, 1);

        // R9 receiver disabled ignores line
        r0 = n_rx;
        cfg_rx_en = 1'b0;
        card_send(8'h3C, 0, 0);
        repeat (4) @(negedge clk);
        chk(n_rx == r0 && rx_valid == 1'b0, "R9", "bytes with rx off", n_rx - r0, 0);
        cfg_rx_en = 1'b1;

        // R6 hold until taken, R11 receive interrupt
        rx_tag = "R6 hold";
        rx_ready = 1'b0; cfg_rx_ie = 1'b1;
        card_send(8'h7E, 0, 1);
        repeat (10) @(negedge clk);
        chk(rx_valid == 1'b1 && rx_data == 8'h7E, "R6", "held byte", {rx_valid, rx_data}, 9'h17E);
        chk(irq_rx == 1'b1, "R11", "irq_rx with byte", irq_rx, 1);
        rx_ready = 1'b1;
        repeat (2) @(negedge clk);
        chk(rx_valid == 1'b0 && irq_rx == 1'b0, "R11", "irq_rx after take", {rx_valid, irq_rx}, 0);
        cfg_rx_ie = 1'b0;

        // R10 card clock
        cfg_clk_en = 1'b1;
        repeat (4) @(negedge clk);
        toggles = 0; prev = card_clk;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (card_clk != prev) toggles++;
            prev = card_clk;
        end
        chk(toggles >= 19 && toggles <= 21, "R10", "card_clk toggles in 40 cycles", toggles, 20);

        // R9 R10 framing disabled
        cfg_sc_mode = 1'b0;
        repeat (2) @(negedge clk);
        toggles = 0; prev = card_clk;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (card_clk != prev) toggles++;
            prev = card_clk;
        end
        chk(toggles == 0 && card_clk == 1'b0, "R10", "card_clk when off", toggles, 0);
        chk(tx_ready == 1'b0 && line_o == 1'b1, "R9", "tx_ready/line_o when off",
            {tx_ready, line_o}, 1);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule